// File: doc/BRIEF.md
# Inter-Core Interrupt Unit

This unit lets the cores of a small cluster (four by default) interrupt one another through a single shared command port. Every command carries the index of the core that issues it, an opcode and an index argument. The unit holds one sender mask per target core. A raise command sets the issuing core's bit in the target's mask. An acknowledge command clears one bit in the issuing core's own mask. Each target's interrupt output is the OR of its mask, so raises from several senders merge into one asserted line.

Two query commands return their result in a registered readback word. One reports whether a chosen target already has any sender bit pending. The other returns the issuing core's own sender mask, so an interrupt handler can find every core that raised it and acknowledge each one in turn.

Top module: `ipi_hub`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every interrupt output is low and the readback word is zero.
- R2: A raise command (opcode 0, argument = target index) from core s to target t, with t different from s, drives interrupt output t high from the clock edge that accepts the command.
- R3: A raise command whose target equals the issuing core has no effect on any interrupt output or sender mask.
- R4: Raise commands from several senders to one target merge into one asserted line. Repeating a raise for a sender bit that is already set leaves the state unchanged.
- R5: A status command (opcode 1, argument = target index) loads the readback word at the accepting edge: the value is 1 when that target has any sender bit set before the command, and 0 otherwise.
- R6: A source command (opcode 2, argument ignored) loads the readback word with the issuing core's sender mask: bit i set means core i raised it, so core 0 is value 1, core 1 is 2 and core 2 is 4. All higher bits are zero.
- R7: An acknowledge command (opcode 3, argument = sender index) clears only that sender's bit in the issuing core's mask. Other bits and other cores' masks are untouched.
- R8: Interrupt output t is high exactly while any sender bit for t is set. It falls only at an edge that accepts an acknowledge issued by core t.
- R9: When the valid strobe is low, nothing changes. The readback word holds its value on every cycle that does not accept a query command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | Command strobe, one command per cycle |
| cmdOp | input | 2 | Opcode: 0 raise, 1 status, 2 source, 3 acknowledge |
| cmdSrc | input | CORE_W | Index of the issuing core |
| cmdArg | input | CORE_W | Target index (raise, status) or sender index (acknowledge) |
| readback | output | DATA_W | Registered result of the last query |
| irqOut | output | NUM_CORES | One interrupt line per core |

## Verification
The assertions assume that the core indices on the command port are below NUM_CORES, and that one command is presented per valid cycle. They also assume that reset is held for at least one edge before the first command. The stimulus draws the issuing core and the argument from the range of valid core indices. Opcodes are spread over all four values, and the valid strobe is dropped on some cycles. Reset is applied only at the start of the run, so every property starts from a cleared state.

// File: rtl/ipi_hub_pkg.sv
package ipi_hub_pkg;

  typedef enum logic [1:0] {
    OP_RAISE = 2'd0,
    OP_PEEK  = 2'd1,
    OP_WHO   = 2'd2,
    OP_CLEAR = 2'd3
  } opT;

  typedef struct packed {
    logic setBit;
    logic clrBit;
    logic rdStatus;
    logic rdSource;
  } strobeT;

endpackage

// File: rtl/ipi_hub_ctrl.sv
module ipi_hub_ctrl
  import ipi_hub_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [CORE_W-1:0] cmdSrc,
  input  logic [CORE_W-1:0] cmdArg,
  output strobeT            strobes,
  output logic [CORE_W-1:0] rowSel,
  output logic [CORE_W-1:0] colSel
);

  logic argOk;
  logic srcOk;
  opT   op;

  generate
    if (NUM_CORES == (1 << CORE_W)) begin : gFullRange
      assign argOk = 1'b1;
      assign srcOk = 1'b1;
    end else begin : gPartRange
      assign argOk = (int'(cmdArg) < NUM_CORES);
      assign srcOk = (int'(cmdSrc) < NUM_CORES);
    end
  endgenerate

  assign op = opT'(cmdOp);

  always_comb begin
    strobes = '0;
    rowSel  = cmdSrc;
    colSel  = cmdArg;
    if (cmdValid && argOk && srcOk) begin
      case (op)
        OP_RAISE: begin
          rowSel         = cmdArg;
          colSel         = cmdSrc;
          strobes.setBit = (cmdArg != cmdSrc);
        end
        OP_PEEK: begin
          rowSel           = cmdArg;
          strobes.rdStatus = 1'b1;
        end
        OP_WHO: begin
          strobes.rdSource = 1'b1;
        end
        OP_CLEAR: begin
          strobes.clrBit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R3: a raise aimed at the issuing core never produces a set strobe
  a_r3_no_self_raise: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd0 && cmdSrc == cmdArg) |-> !strobes.setBit);

  // R9: an idle command port produces no strobe at all
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (strobes == '0));

  // R9: at most one action per accepted command
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/ipi_hub_dp.sv
module ipi_hub_dp
  import ipi_hub_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strobes,
  input  logic [CORE_W-1:0]    rowSel,
  input  logic [CORE_W-1:0]    colSel,
  output logic [DATA_W-1:0]    readback,
  output logic [NUM_CORES-1:0] irqOut
);

  localparam int CELLS = NUM_CORES * NUM_CORES;
  localparam int IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1;

  logic [CELLS-1:0]     pendVec;
  logic [NUM_CORES-1:0] selRow;
  logic [DATA_W-1:0]    rowWide;
  logic [IDX_W-1:0]     cellIdx;

  genvar t, s;
  generate
    for (t = 0; t < NUM_CORES; t++) begin : gTarget
      for (s = 0; s < NUM_CORES; s++) begin : gSender
        logic hit;
        assign hit = (rowSel == CORE_W'(t)) && (colSel == CORE_W'(s));
        always_ff @(posedge clk) begin
          if (!rstN) begin
            pendVec[t*NUM_CORES+s] <= 1'b0;
          end else if (strobes.setBit && hit) begin
            pendVec[t*NUM_CORES+s] <= 1'b1;
          end else if (strobes.clrBit && hit) begin
            pendVec[t*NUM_CORES+s] <= 1'b0;
          end
        end
      end
      assign irqOut[t] = |pendVec[t*NUM_CORES +: NUM_CORES];

      // R8: a line only drops after an acknowledge issued by its own core
      a_r8_drop_on_ack: assert property (@(posedge clk) disable iff (!rstN)
        $fell(irqOut[t]) |-> ($past(strobes.clrBit) && $past(rowSel) == CORE_W'(t)));
    end
  endgenerate

  assign selRow  = pendVec[rowSel*NUM_CORES +: NUM_CORES];
  assign cellIdx = IDX_W'(int'(rowSel) * NUM_CORES + int'(colSel));

  always_comb begin
    rowWide = '0;
    rowWide[NUM_CORES-1:0] = selRow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readback <= '0;
    end else if (strobes.rdStatus) begin
      readback <= DATA_W'(|selRow);
    end else if (strobes.rdSource) begin
      readback <= rowWide;
    end
  end

  // R4: a raised sender bit is set after the accepting edge
  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setBit |=> pendVec[$past(cellIdx)]);

  // R7: the acknowledged sender bit is clear after the accepting edge
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrBit |=> !pendVec[$past(cellIdx)]);

  // R5: status readback reflects the target's state before the query
  a_r5_status_value: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdStatus |=> (readback == DATA_W'($past(irqOut[rowSel]))));

  // R9: readback holds when no query is accepted
  a_r9_readback_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.rdStatus || strobes.rdSource) |=> $stable(readback));

endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_hub_pkg::*;
#(
  parameter int  NUM_CORES = 4,
  parameter int  DATA_W    = 32,
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [CORE_W-1:0]    cmdSrc,
  input  logic [CORE_W-1:0]    cmdArg,
  output logic [DATA_W-1:0]    readback,
  output logic [NUM_CORES-1:0] irqOut
);

  strobeT            strobes;
  logic [CORE_W-1:0] rowSel;
  logic [CORE_W-1:0] colSel;

  ipi_hub_ctrl #(
    .NUM_CORES(NUM_CORES),
    .CORE_W   (CORE_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdSrc  (cmdSrc),
    .cmdArg  (cmdArg),
    .strobes (strobes),
    .rowSel  (rowSel),
    .colSel  (colSel)
  );

  ipi_hub_dp #(
    .NUM_CORES(NUM_CORES),
    .DATA_W   (DATA_W),
    .CORE_W   (CORE_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rowSel  (rowSel),
    .colSel  (colSel),
    .readback(readback),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/sim_ipi_hub.sv
`timescale 1ns/1ps
module sim_ipi_hub;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [1:0]  cmdOp;
  logic [1:0]  cmdSrc;
  logic [1:0]  cmdArg;
  logic [31:0] readback;
  logic [3:0]  irqOut;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 1'b0;

  logic [3:0]  mPend [4];
  logic [31:0] mRb;

  always #2.5 clk = ~clk;

  ipi_hub #(.NUM_CORES(4), .DATA_W(32)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSrc(cmdSrc), .cmdArg(cmdArg), .readback(readback), .irqOut(irqOut)
  );

  function automatic logic [3:0] expIrq();
    logic [3:0] r;
    for (int t = 0; t < 4; t++) r[t] = |mPend[t];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; drives one command, updates the model, checks at next negedge.
  task automatic step(input logic v, input logic [1:0] op, input logic [1:0] src,
                      input logic [1:0] arg, input string tag);
    cmdValid = v; cmdOp = op; cmdSrc = src; cmdArg = arg;
    @(posedge clk);
    if (v) begin
      case (op)
        2'd0: if (arg != src) mPend[arg][src] = 1'b1;
        2'd1: mRb = {31'b0, |mPend[arg]};
        2'd2: mRb = {28'b0, mPend[src]};
        default: mPend[src][arg] = 1'b0;
      endcase
    end
    @(negedge clk);
    cmdValid = 1'b0;
    chk({tag, " irq"}, {28'b0, irqOut}, {28'b0, expIrq()});
    chk({tag, " readback"}, readback, mRb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) mPend[i] = 4'b0;
    mRb = 32'b0;
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 2'd0; cmdSrc = 2'd0; cmdArg = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset irq", {28'b0, irqOut}, 32'b0);
    chk("R1 reset readback", readback, 32'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release irq", {28'b0, irqOut}, 32'b0);

    // Directed corner cases
    step(1'b1, 2'd0, 2'd2, 2'd2, "R3 self raise");
    chk("R3 line stays low", {31'b0, irqOut[2]}, 32'b0);
    step(1'b1, 2'd0, 2'd1, 2'd0, "R2 raise 1->0");
    chk("R2 line 0 high", {31'b0, irqOut[0]}, 32'd1);
    step(1'b1, 2'd0, 2'd2, 2'd0, "R4 merge 2->0");
    step(1'b1, 2'd0, 2'd1, 2'd0, "R4 repeat 1->0");
    step(1'b1, 2'd1, 2'd3, 2'd0, "R5 status target 0");
    chk("R5 pending target", readback, 32'd1);
    step(1'b1, 2'd1, 2'd0, 2'd3, "R5 status target 3");
    chk("R5 idle target", readback, 32'd0);
    step(1'b1, 2'd2, 2'd0, 2'd3, "R6 source mask core 0");
    chk("R6 two senders", readback, 32'h6);
    step(1'b1, 2'd3, 2'd0, 2'd1, "R7 ack sender 1");
    chk("R8 still high", {31'b0, irqOut[0]}, 32'd1);
    step(1'b0, 2'd0, 2'd3, 2'd1, "R9 invalid raise");
    chk("R9 readback held", readback, 32'h6);
    step(1'b1, 2'd2, 2'd0, 2'd0, "R6 source after ack");
    chk("R7 one bit left", readback, 32'h4);
    step(1'b1, 2'd3, 2'd1, 2'd2, "R7 ack on other core");
    chk("R7 core 0 untouched", {31'b0, irqOut[0]}, 32'd1);
    step(1'b1, 2'd3, 2'd0, 2'd2, "R8 last ack");
    chk("R8 line falls", {31'b0, irqOut[0]}, 32'd0);

    // Constrained random traffic
    for (int i = 0; i < 2000; i++) begin
      logic       v;
      logic [1:0] op;
      v  = ($urandom % 8) != 0;
      op = 2'($urandom % 4);
      case (op)
        2'd0:    step(v, op, 2'($urandom % 4), 2'($urandom % 4), "R2 R3 R4 rnd raise");
        2'd1:    step(v, op, 2'($urandom % 4), 2'($urandom % 4), "R5 R9 rnd status");
        2'd2:    step(v, op, 2'($urandom % 4), 2'($urandom % 4), "R6 R9 rnd source");
        default: step(v, op, 2'($urandom % 4), 2'($urandom % 4), "R7 R8 rnd ack");
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule